// File: doc/BRIEF.md
# Compressed Opcode Page Stack Controller

This block keeps the state that tells a compressed-instruction decoder which opcode page is currently in force. Decoded commands from the front end arrive as single-cycle strobes: a page push carries a 3-bit subpage number and a 4-bit activation length, a pop drops the newest page, and a return-to-base command empties the stack so that decoding falls back to the standard instruction set. Up to four pages may be stacked; only the newest one is visible to the decoder.

Each stacked page counts down its own activation length as instructions retire and leaves the stack when the count runs out, unless its length is all ones, which marks it as held until removed explicitly. A taken branch strips the temporary pages off the top of the stack. The whole state packs into a 31-bit word that a control-register port reads continuously and may overwrite, so software can save and restore the page context across calls and traps.

Top module: `cpage_stack`

## Requirements
- R1: A push (`pg_push`) on a stack holding fewer than four pages places {`pg_sub`, `pg_len`} on top and raises the depth by one; `cur_sub` then shows the new page's subpage number.
- R2: A retire pulse with no command pending decrements the top page's length by one when that length is not 4'b1111; when the length is 1 or 0 the top page is removed instead; a length of 4'b1111 is left unchanged.
- R3: A push when the depth is already 4 leaves the state unchanged, and `push_ovf` is high for exactly the one cycle after that push.
- R4: A pop removes only the top page; a pop with depth 0 changes nothing.
- R5: A return-to-base command (`pg_base`) sets the depth to 0 and clears every slot.
- R6: A branch removes pages from the top of the stack for as long as the top page's length is not 4'b1111, stopping at the first held page or at depth 0.
- R7: `csr_rd` is the state word: bits [30:28] depth, and slot i (0 = bottom) at bits [7i+6:7i], each slot as subpage in its upper 3 bits and length in its lower 4 bits; slots at or above the depth read zero.
- R8: A control-register write (`csr_we`) loads `csr_wd` in place of any command in the same cycle; a depth above 4 is stored as 4, and slots at or above the stored depth are cleared.
- R9: With depth 0, `base_mode` is 1 and `cur_sub` is 0; this is also the state after reset.
- R10: When several strobes arrive together, only the highest-ranked acts, in the order write, return-to-base, pop, push, branch, retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pg_push | input | 1 | Push a page |
| pg_sub | input | 3 | Subpage number for a push |
| pg_len | input | 4 | Activation length for a push (4'b1111 = held) |
| pg_pop | input | 1 | Remove the top page |
| pg_base | input | 1 | Return to base decoding, empty the stack |
| retire | input | 1 | One instruction retired |
| branch | input | 1 | Branch taken |
| csr_we | input | 1 | Load the state word from `csr_wd` |
| csr_wd | input | 31 | State word to load |
| csr_rd | output | 31 | Current state word |
| cur_sub | output | 3 | Subpage number of the top page |
| base_mode | output | 1 | High when no page is active |
| push_ovf | output | 1 | A push was dropped on a full stack last cycle |

## Verification
The bench targets the countdown's end points: a page pushed with length 0 or 1 must leave on the next retire, while a held page must survive any number of retires and branches; an off-by-one counter would leave a page active for one instruction too many. It drives a branch over a mix of temporary and held pages, where a design that cleared everything or only the top page would show the wrong subpage. It pushes onto a full stack and pops an empty one, where a wrapping depth counter would corrupt the bottom slot or underflow to 7. It loads out-of-range depths and stale slot contents through the register port alongside a competing command, which a design with the wrong priority or no clamping would let through.

// File: rtl/cpage_stack.sv
`timescale 1ns/1ps
module cpage_stack #(
  parameter int SLOTS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pg_push,
  input  logic [2:0]  pg_sub,
  input  logic [3:0]  pg_len,
  input  logic        pg_pop,
  input  logic        pg_base,
  input  logic        retire,
  input  logic        branch,
  input  logic        csr_we,
  input  logic [30:0] csr_wd,
  output logic [30:0] csr_rd,
  output logic [2:0]  cur_sub,
  output logic        base_mode,
  output logic        push_ovf
);
  localparam logic [3:0] HELD = 4'b1111;
  localparam logic [2:0] FULL = 3'(SLOTS);

  logic [SLOTS-1:0][6:0] slot, slot_n;
  logic [2:0] depth, depth_n;
  logic       ovf_n;
  logic [1:0] top;

  assign top       = 2'(depth - 3'd1);
  assign base_mode = (depth == 3'd0);
  assign cur_sub   = base_mode ? 3'd0 : slot[top][6:4];
  assign csr_rd    = {depth, slot};

  always_comb begin
    slot_n  = slot;
    depth_n = depth;
    ovf_n   = 1'b0;
    if (csr_we) begin
      depth_n = (csr_wd[30:28] > FULL) ? FULL : csr_wd[30:28];
      for (int i = 0; i < SLOTS; i++)
        slot_n[i] = (3'(i) < depth_n) ? csr_wd[7*i +: 7] : 7'd0;
    end else if (pg_base) begin
      slot_n  = '0;
      depth_n = 3'd0;
    end else if (pg_pop) begin
      if (depth != 3'd0) begin
        slot_n[top] = 7'd0;
        depth_n     = depth - 3'd1;
      end
    end else if (pg_push) begin
      if (depth == FULL) ovf_n = 1'b1;
      else begin
        slot_n[depth[1:0]] = {pg_sub, pg_len};
        depth_n            = depth + 3'd1;
      end
    end else if (branch) begin
      for (int i = SLOTS-1; i >= 0; i--)
        if (depth_n != 3'd0 && 3'(i) == depth_n - 3'd1 && slot_n[i][3:0] != HELD) begin
          slot_n[i] = 7'd0;
          depth_n   = depth_n - 3'd1;
        end
    end else if (retire && depth != 3'd0) begin
      if (slot[top][3:0] == HELD) ;
      else if (slot[top][3:0] <= 4'd1) begin
        slot_n[top] = 7'd0;
        depth_n     = depth - 3'd1;
      end else
        slot_n[top][3:0] = slot[top][3:0] - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot     <= '0;
      depth    <= 3'd0;
      push_ovf <= 1'b0;
    end else begin
      slot     <= slot_n;
      depth    <= depth_n;
      push_ovf <= ovf_n;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd[30:28] <= FULL);
  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_push && !csr_we && !pg_base && !pg_pop && csr_rd[30:28] == FULL)
    |=> (push_ovf && $stable(csr_rd)));
  a_r5_base_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_base && !csr_we) |=> (csr_rd == 31'd0));
  a_r8_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wd[30:28] == FULL) |=> (csr_rd == $past(csr_wd)));
  a_r9_base_shows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    base_mode |-> (cur_sub == 3'd0 && csr_rd == 31'd0));
  a_r2_held_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !csr_we && !pg_base && !pg_pop && !pg_push && !branch
     && !base_mode && csr_rd[3:0] == HELD && csr_rd[30:28] == 3'd1)
    |=> $stable(csr_rd));
endmodule

// File: tb/cpage_stack_tb_top.sv
`timescale 1ns/1ps
module cpage_stack_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_push = 0, pg_pop = 0, pg_base = 0, retire = 0, branch = 0, csr_we = 0;
  logic [2:0] pg_sub = 0;
  logic [3:0] pg_len = 0;
  logic [30:0] csr_wd = 0;
  logic [30:0] csr_rd;
  logic [2:0] cur_sub;
  logic base_mode, push_ovf;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cpage_stack dut_i (.clk, .rst_n, .pg_push, .pg_sub, .pg_len, .pg_pop, .pg_base,
    .retire, .branch, .csr_we, .csr_wd, .csr_rd, .cur_sub, .base_mode, .push_ovf);

  // op: 0 idle, 1 push, 2 pop, 3 base, 4 retire, 5 branch
  // vector: {op[2:0], sub[2:0], len[3:0], exp_sub[2:0], exp_base, exp_depth[2:0]}
  localparam logic [16:0] VEC [19] = '{
    {3'd1,3'd3,4'd2,  3'd3,1'b0,3'd1},  // R1
    {3'd4,3'd0,4'd0,  3'd3,1'b0,3'd1},  // R2 2->1
    {3'd4,3'd0,4'd0,  3'd0,1'b1,3'd0},  // R2 1->pop
    {3'd1,3'd5,4'd15, 3'd5,1'b0,3'd1},  // R1
    {3'd4,3'd0,4'd0,  3'd5,1'b0,3'd1},  // R2 held
    {3'd1,3'd2,4'd3,  3'd2,1'b0,3'd2},
    {3'd1,3'd6,4'd1,  3'd6,1'b0,3'd3},
    {3'd5,3'd0,4'd0,  3'd5,1'b0,3'd1},  // R6 strips two
    {3'd1,3'd1,4'd4,  3'd1,1'b0,3'd2},
    {3'd2,3'd0,4'd0,  3'd5,1'b0,3'd1},  // R4
    {3'd2,3'd0,4'd0,  3'd0,1'b1,3'd0},  // R4
    {3'd2,3'd0,4'd0,  3'd0,1'b1,3'd0},  // R4 empty
    {3'd1,3'd7,4'd15, 3'd7,1'b0,3'd1},
    {3'd5,3'd0,4'd0,  3'd7,1'b0,3'd1},  // R6 held stays
    {3'd1,3'd4,4'd2,  3'd4,1'b0,3'd2},
    {3'd3,3'd0,4'd0,  3'd0,1'b1,3'd0},  // R5
    {3'd1,3'd2,4'd0,  3'd2,1'b0,3'd1},
    {3'd4,3'd0,4'd0,  3'd0,1'b1,3'd0},  // R2 length 0
    {3'd0,3'd0,4'd0,  3'd0,1'b1,3'd0}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] op, input logic [2:0] sp, input logic [3:0] ln);
    @(negedge clk);
    pg_push = (op == 3'd1); pg_pop = (op == 3'd2); pg_base = (op == 3'd3);
    retire = (op == 3'd4); branch = (op == 3'd5);
    pg_sub = sp; pg_len = ln;
    @(posedge clk); #1;
    {pg_push, pg_pop, pg_base, retire, branch, csr_we} = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset word", 32'(csr_rd), 0);
    chk("R9 reset base", 32'(base_mode), 1);
    chk("R9 reset sub", 32'(cur_sub), 0);
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[k]) begin
      step(VEC[k][16:14], VEC[k][13:11], VEC[k][10:7]);
      chk($sformatf("R1/R2/R4/R5/R6 vec%0d sub", k), 32'(cur_sub), 32'(VEC[k][6:4]));
      chk($sformatf("R9 vec%0d base", k), 32'(base_mode), 32'(VEC[k][3]));
      chk($sformatf("R7 vec%0d depth", k), 32'(csr_rd[30:28]), 32'(VEC[k][2:0]));
    end

    // R3 overflow
    for (int i = 1; i <= 4; i++) step(3'd1, 3'(i), 4'd15);
    chk("R7 packed full word", 32'(csr_rd),
        32'({3'd4, 3'd4,4'hF, 3'd3,4'hF, 3'd2,4'hF, 3'd1,4'hF}));
    step(3'd1, 3'd7, 4'd2);
    chk("R3 full push word", 32'(csr_rd),
        32'({3'd4, 3'd4,4'hF, 3'd3,4'hF, 3'd2,4'hF, 3'd1,4'hF}));
    chk("R3 overflow flag", 32'(push_ovf), 1);
    step(3'd0, 3'd0, 4'd0);
    chk("R3 overflow one cycle", 32'(push_ovf), 0);

    // R10 pop wins over push
    @(negedge clk); pg_pop = 1; pg_push = 1; pg_sub = 3'd6; pg_len = 4'd5;
    @(posedge clk); #1; {pg_pop, pg_push} = '0;
    chk("R10 pop over push depth", 32'(csr_rd[30:28]), 3);
    chk("R10 pop over push sub", 32'(cur_sub), 3);

    // R8 write beats base, stale slots cleared
    @(negedge clk); csr_we = 1; pg_base = 1;
    csr_wd = {3'd2, 7'h55, 7'h2A, 3'd5,4'd3, 3'd1,4'hF};
    @(posedge clk); #1; {csr_we, pg_base} = '0;
    chk("R8 write priority word", 32'(csr_rd), 32'({3'd2, 14'd0, 3'd5,4'd3, 3'd1,4'hF}));
    chk("R8 write sub", 32'(cur_sub), 5);

    // R6 branch clears temp top, stops at held
    step(3'd5, 3'd0, 4'd0);
    chk("R6 branch stop word", 32'(csr_rd), 32'({3'd1, 21'd0, 3'd1,4'hF}));

    // R8 depth clamp
    @(negedge clk); csr_we = 1; csr_wd = {3'd7, 7'h12, 7'h23, 7'h34, 7'h45};
    @(posedge clk); #1; csr_we = 0;
    chk("R8 depth clamp", 32'(csr_rd), 32'({3'd4, 7'h12, 7'h23, 7'h34, 7'h45}));

    // R5 base then R6 branch over all temporaries, R2 retire on empty
    step(3'd3, 3'd0, 4'd0);
    step(3'd1, 3'd2, 4'd6);
    step(3'd1, 3'd3, 4'd9);
    step(3'd5, 3'd0, 4'd0);
    chk("R6 branch empties", 32'(csr_rd), 0);
    step(3'd4, 3'd0, 4'd0);
    chk("R2 retire on empty", 32'(csr_rd), 0);
    chk("R9 empty base", 32'(base_mode), 1);

    finish_run();
  end
endmodule